// File: doc/BRIEF.md
# Branch Target Calculator

This unit works out where execution continues after a control-transfer instruction in a 16-bit segmented processor. Each request gives it the current code segment and instruction pointer, a branch kind and the operands that kind needs. It returns the new code segment, the new instruction pointer and a flag that says whether the branch was taken. The supported kinds are: relative within the segment, with an 8-bit or a 16-bit signed displacement; indirect within the segment, through a register or memory word; direct to another segment, with an immediate segment:offset pair; and indirect to another segment, through two memory words.

Fetching the memory operands and evaluating the flags happen elsewhere. The unit receives the memory words as already fetched, and receives a condition bit that is already resolved. Only the two far kinds change the code segment. The current instruction pointer input is the address of the instruction that follows the branch. A request is presented with a one-cycle valid strobe, and the result appears on registered outputs together with a done strobe on the next cycle.

Top module: `branch_target_unit`

## Requirements
- R1: While reset is asserted, and after it until the first request, doneOut and takenOut are low and csOut and ipOut are zero.
- R2: doneOut is high in exactly the cycle after a cycle with validIn high. Cycles without validIn leave csOut, ipOut and takenOut unchanged.
- R3: Kind code 0 (relative, short) sets ipOut to ipIn plus the sign-extended low byte of dispIn and keeps csOut equal to csIn. dispIn[15:8] has no effect.
- R4: Kind code 1 (relative, near) sets ipOut to ipIn plus the full 16-bit signed dispIn and keeps csOut equal to csIn.
- R5: Kind code 2 (near indirect) sets ipOut to nearWordIn and keeps csOut equal to csIn.
- R6: Kind code 3 (far direct) sets csOut to farImmIn[31:16] and ipOut to farImmIn[15:0].
- R7: Kind code 4 (far indirect) sets ipOut to memLoIn, the word at the lower address, and csOut to memHiIn, the word that follows it.
- R8: When condIn is high and condTrue is low, takenOut is low, ipOut equals ipIn and csOut equals csIn, whatever the kind. When condIn is low, or condTrue is high, kind codes 0 to 4 give takenOut high.
- R9: Kind codes 5 to 7 are not taken. They give takenOut low, ipOut equal to ipIn and csOut equal to csIn.
- R10: Relative arithmetic wraps modulo 2^16. A forward step past 0xFFFF comes back near 0x0000, and a backward step below 0x0000 comes back near 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Request strobe; the operands below are sampled in this cycle |
| kindIn | input | 3 | Branch kind: 0 rel8, 1 rel16, 2 near indirect, 3 far direct, 4 far indirect |
| condIn | input | 1 | High for a conditional branch |
| condTrue | input | 1 | Resolved branch condition |
| csIn | input | 16 | Current code segment |
| ipIn | input | 16 | Address of the instruction after the branch |
| dispIn | input | 16 | Signed displacement; only the low byte is used for kind 0 |
| nearWordIn | input | 16 | Register or memory word for a near indirect branch |
| farImmIn | input | 32 | Immediate target: segment in the upper half, offset in the lower half |
| memLoIn | input | 16 | Far indirect word at the lower address (new offset) |
| memHiIn | input | 16 | Far indirect word at the next address (new segment) |
| doneOut | output | 1 | Result strobe, one cycle after validIn |
| csOut | output | 16 | New code segment |
| ipOut | output | 16 | New instruction pointer |
| takenOut | output | 1 | High when the branch transfers control |

## Verification
A wrong select inside the control shows up at the ports one cycle after the request. It appears either as a code segment that changed on a near kind or as a result built from the wrong operand word. The bench fills every operand that the current kind does not use with unrelated random data so that such a mix-up cannot hide. A register that loads when no request is present shows up as outputs that change during the idle cycle that follows each checked result. A sign-extension fault is caught by displacements at 0x7F and 0x80 and by steps that wrap across 0xFFFF.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int WORD_W  = 16;
  localparam int SHORT_W = 8;
  localparam int KIND_W  = 3;

  localparam logic [KIND_W-1:0] KIND_REL8    = 3'd0;
  localparam logic [KIND_W-1:0] KIND_REL16   = 3'd1;
  localparam logic [KIND_W-1:0] KIND_NEARIND = 3'd2;
  localparam logic [KIND_W-1:0] KIND_FARDIR  = 3'd3;
  localparam logic [KIND_W-1:0] KIND_FARIND  = 3'd4;

  typedef enum logic [2:0] {
    IPS_KEEP, IPS_REL8, IPS_REL16, IPS_NEAR, IPS_FARIMM, IPS_FARMEM
  } ipSel_e;

  typedef enum logic [1:0] {
    CSS_KEEP, CSS_IMM, CSS_MEM
  } csSel_e;

  typedef struct packed {
    logic   load;
    logic   taken;
    ipSel_e ipSel;
    csSel_e csSel;
  } ctl_t;
endpackage

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
#(
  parameter int KW = KIND_W
) (
  input  logic          validIn,
  input  logic [KW-1:0] kindIn,
  input  logic          condIn,
  input  logic          condTrue,
  output ctl_t          ctl
);
  logic goAhead;

  always_comb begin
    goAhead   = !condIn || condTrue;
    ctl.load  = validIn;
    ctl.taken = 1'b0;
    ctl.ipSel = IPS_KEEP;
    ctl.csSel = CSS_KEEP;
    if (goAhead) begin
      ctl.taken = 1'b1;
      case (kindIn)
        KIND_REL8:    ctl.ipSel = IPS_REL8;
        KIND_REL16:   ctl.ipSel = IPS_REL16;
        KIND_NEARIND: ctl.ipSel = IPS_NEAR;
        KIND_FARDIR: begin
          ctl.ipSel = IPS_FARIMM;
          ctl.csSel = CSS_IMM;
        end
        KIND_FARIND: begin
          ctl.ipSel = IPS_FARMEM;
          ctl.csSel = CSS_MEM;
        end
        default:      ctl.taken = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SHORT_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctl_t           ctl,
  input  logic [W-1:0]   csIn,
  input  logic [W-1:0]   ipIn,
  input  logic [W-1:0]   dispIn,
  input  logic [W-1:0]   nearWordIn,
  input  logic [2*W-1:0] farImmIn,
  input  logic [W-1:0]   memLoIn,
  input  logic [W-1:0]   memHiIn,
  output logic           doneOut,
  output logic [W-1:0]   csOut,
  output logic [W-1:0]   ipOut,
  output logic           takenOut
);
  localparam int EXT_W = W - SW;

  logic [W-1:0] shortExt;
  logic [W-1:0] relShort;
  logic [W-1:0] relNear;
  logic [W-1:0] ipNext;
  logic [W-1:0] csNext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign shortExt = {{EXT_W{dispIn[SW-1]}}, dispIn[SW-1:0]};
    end else begin : g_noext
      assign shortExt = dispIn;
    end
  endgenerate

  // both adders wrap at the word width
  assign relShort = ipIn + shortExt;
  assign relNear  = ipIn + dispIn;

  always_comb begin
    case (ctl.ipSel)
      IPS_REL8:   ipNext = relShort;
      IPS_REL16:  ipNext = relNear;
      IPS_NEAR:   ipNext = nearWordIn;
      IPS_FARIMM: ipNext = farImmIn[W-1:0];
      IPS_FARMEM: ipNext = memLoIn;
      default:    ipNext = ipIn;
    endcase
    case (ctl.csSel)
      CSS_IMM: csNext = farImmIn[2*W-1:W];
      CSS_MEM: csNext = memHiIn;
      default: csNext = csIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneOut  <= 1'b0;
      csOut    <= '0;
      ipOut    <= '0;
      takenOut <= 1'b0;
    end else begin
      doneOut <= ctl.load;
      if (ctl.load) begin
        csOut    <= csNext;
        ipOut    <= ipNext;
        takenOut <= ctl.taken;
      end
    end
  end
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import bt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                validIn,
  input  logic [KIND_W-1:0]   kindIn,
  input  logic                condIn,
  input  logic                condTrue,
  input  logic [WORD_W-1:0]   csIn,
  input  logic [WORD_W-1:0]   ipIn,
  input  logic [WORD_W-1:0]   dispIn,
  input  logic [WORD_W-1:0]   nearWordIn,
  input  logic [2*WORD_W-1:0] farImmIn,
  input  logic [WORD_W-1:0]   memLoIn,
  input  logic [WORD_W-1:0]   memHiIn,
  output logic                doneOut,
  output logic [WORD_W-1:0]   csOut,
  output logic [WORD_W-1:0]   ipOut,
  output logic                takenOut
);
  ctl_t ctl;

  bt_ctrl #(.KW(KIND_W)) i_ctrl (
    .validIn (validIn),
    .kindIn  (kindIn),
    .condIn  (condIn),
    .condTrue(condTrue),
    .ctl     (ctl)
  );

  bt_datapath #(.W(WORD_W), .SW(SHORT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .csIn      (csIn),
    .ipIn      (ipIn),
    .dispIn    (dispIn),
    .nearWordIn(nearWordIn),
    .farImmIn  (farImmIn),
    .memLoIn   (memLoIn),
    .memHiIn   (memHiIn),
    .doneOut   (doneOut),
    .csOut     (csOut),
    .ipOut     (ipOut),
    .takenOut  (takenOut)
  );
endmodule

// File: rtl/bt_checker.sv
module bt_checker
  import bt_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                validIn,
  input logic [KIND_W-1:0]   kindIn,
  input logic                condIn,
  input logic                condTrue,
  input logic [WORD_W-1:0]   csIn,
  input logic [WORD_W-1:0]   ipIn,
  input logic [WORD_W-1:0]   nearWordIn,
  input logic [2*WORD_W-1:0] farImmIn,
  input logic [WORD_W-1:0]   memLoIn,
  input logic [WORD_W-1:0]   memHiIn,
  input logic                doneOut,
  input logic [WORD_W-1:0]   csOut,
  input logic [WORD_W-1:0]   ipOut,
  input logic                takenOut
);
  logic go;
  assign go = !condIn || condTrue;

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> doneOut); // R2
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !doneOut); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(csOut) && $stable(ipOut) && $stable(takenOut))); // R2
  AST_NEAR_KEEPS_CS: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && kindIn <= KIND_NEARIND) |=> csOut == $past(csIn)); // R5
  AST_NEAR_IND: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && go && kindIn == KIND_NEARIND) |=> ipOut == $past(nearWordIn)); // R5
  AST_FAR_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && go && kindIn == KIND_FARDIR) |=>
      ({csOut, ipOut} == $past(farImmIn) && takenOut)); // R6
  AST_FAR_INDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && go && kindIn == KIND_FARIND) |=>
      (ipOut == $past(memLoIn) && csOut == $past(memHiIn))); // R7
  AST_COND_FALSE: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && condIn && !condTrue) |=>
      (!takenOut && ipOut == $past(ipIn) && csOut == $past(csIn))); // R8
  AST_BAD_KIND: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && kindIn > KIND_FARIND) |=>
      (!takenOut && ipOut == $past(ipIn) && csOut == $past(csIn))); // R9
endmodule

bind branch_target_unit bt_checker i_bt_checker (.*);

// File: tb/test_branch_target_unit.sv
module test_branch_target_unit;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 32'h5EED_0B7C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [2:0]  kindIn = '0;
  logic        condIn = 1'b0;
  logic        condTrue = 1'b0;
  logic [15:0] csIn = '0, ipIn = '0, dispIn = '0, nearWordIn = '0;
  logic [31:0] farImmIn = '0;
  logic [15:0] memLoIn = '0, memHiIn = '0;
  logic        doneOut, takenOut;
  logic [15:0] csOut, ipOut;

  int vectors = 0;
  int misses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_unit i_branch_target_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .kindIn(kindIn),
    .condIn(condIn), .condTrue(condTrue), .csIn(csIn), .ipIn(ipIn),
    .dispIn(dispIn), .nearWordIn(nearWordIn), .farImmIn(farImmIn),
    .memLoIn(memLoIn), .memHiIn(memHiIn), .doneOut(doneOut),
    .csOut(csOut), .ipOut(ipOut), .takenOut(takenOut)
  );

  // expected {cs, ip, taken} from the requirements
  function automatic logic [32:0] model(
    input logic [2:0] k, input logic c, input logic t,
    input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] d,
    input logic [15:0] nw, input logic [31:0] fi,
    input logic [15:0] lo, input logic [15:0] hi);
    logic [15:0] sx;
    sx = {{8{d[7]}}, d[7:0]};
    if (c && !t) return {cs, ip, 1'b0};             // R8
    case (k)
      3'd0: return {cs, 16'(ip + sx), 1'b1};        // R3, R10
      3'd1: return {cs, 16'(ip + d), 1'b1};         // R4, R10
      3'd2: return {cs, nw, 1'b1};                  // R5
      3'd3: return {fi, 1'b1};                      // R6
      3'd4: return {hi, lo, 1'b1};                  // R7
      default: return {cs, ip, 1'b0};               // R9
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] k, input logic c,
    input logic t, input logic [15:0] cs, input logic [15:0] ip,
    input logic [15:0] d, input logic [15:0] nw, input logic [31:0] fi,
    input logic [15:0] lo, input logic [15:0] hi);
    logic [32:0] e;
    e = model(k, c, t, cs, ip, d, nw, fi, lo, hi);
    @(negedge clk);
    validIn = 1'b1; kindIn = k; condIn = c; condTrue = t; csIn = cs; ipIn = ip;
    dispIn = d; nearWordIn = nw; farImmIn = fi; memLoIn = lo; memHiIn = hi;
    @(negedge clk);
    validIn = 1'b0;
    kindIn = 3'($urandom); csIn = 16'($urandom); ipIn = 16'($urandom);
    memLoIn = 16'($urandom); memHiIn = 16'($urandom); farImmIn = $urandom;
    check({req, " R2 done"}, 64'(doneOut), 64'(1));
    check(req, 64'({csOut, ipOut, takenOut}), 64'(e));
    @(negedge clk);
    check("R2 idle", 64'({doneOut, csOut, ipOut, takenOut}), 64'({1'b0, e}));
  endtask

  function automatic logic [15:0] r16();
    return 16'($urandom);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    misses++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    check("R1 reset", 64'({doneOut, csOut, ipOut, takenOut}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'({doneOut, csOut, ipOut, takenOut}), 64'(0));

    apply("R3 disp 0x80 upper junk", 3'd0, 0, 0, 16'h1234, 16'h0010, 16'hAB80, r16(), $urandom, r16(), r16());
    apply("R3 disp 0x7F", 3'd0, 0, 0, 16'h2000, 16'h0100, 16'h557F, r16(), $urandom, r16(), r16());
    apply("R10 rel8 wrap up", 3'd0, 1, 1, 16'h0700, 16'hFFF8, 16'h0010, r16(), $urandom, r16(), r16());
    apply("R10 rel16 wrap down", 3'd1, 0, 0, 16'h0700, 16'h0004, 16'hFFF0, r16(), $urandom, r16(), r16());
    apply("R4 rel16 forward", 3'd1, 0, 0, 16'h0900, 16'h1000, 16'h0100, r16(), $urandom, r16(), r16());
    apply("R5 near indirect", 3'd2, 0, 0, 16'h0800, 16'h4444, r16(), 16'hBEEF, $urandom, r16(), r16());
    apply("R6 far direct", 3'd3, 0, 0, 16'h0800, 16'h4444, r16(), r16(), 32'hF000_1230, r16(), r16());
    apply("R7 far indirect", 3'd4, 1, 1, 16'h0800, 16'h4444, r16(), r16(), $urandom, 16'h0123, 16'hCAFE);
    apply("R8 cond false far", 3'd3, 1, 0, 16'h0A0A, 16'h5050, r16(), r16(), 32'h1111_2222, r16(), r16());
    apply("R8 cond false rel8", 3'd0, 1, 0, 16'h0A0A, 16'h6060, 16'h0040, r16(), $urandom, r16(), r16());
    apply("R9 kind 6", 3'd6, 0, 0, 16'h0B0B, 16'h7070, r16(), r16(), $urandom, r16(), r16());
    apply("R9 kind 5", 3'd5, 0, 1, 16'h0C0C, 16'h8080, r16(), r16(), $urandom, r16(), r16());

    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      k = (($urandom % 8) == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      apply("R3-R9 random kind", k, 1'($urandom), 1'($urandom % 4 != 0), r16(), r16(),
            r16(), r16(), $urandom, r16(), r16());
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule